// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block is one logic cell of a programmable-logic fabric. It takes five product-term values, computed by an AND array outside the block. Static configuration bits steer these terms into a sum, a polarity/XOR stage, a storage element and the control inputs of that element. The storage element can act as a D, T, JK or SR flip-flop or as a level-sensitive latch. Its data source, clock, clock enable, reset and preset are each chosen on their own. The pin output, the buried feedback and the output enable are also chosen independently.

The whole cell runs on one system clock `clk`. The fabric clock is either the global clock or a product term, and it is sampled on that system clock. A rising fabric edge is found by comparing the current level of the chosen clock with the level one system cycle earlier. The state then changes at that same system edge. Reset and preset act at the next system edge whenever they are active, and they override any clock activity. The configuration is captured while `rst_n` is low and is frozen while the block runs.

Top module: `plm_macrocell`

## Requirements
- R1: While `rst_n` is low, the stored state clears to 0 and the configuration inputs are captured. Configuration changes made after reset is released have no effect until the next reset.
- R2: The sum is the OR of the product terms whose bit is set in `cfg_sum_mask`. When `cfg_cas_en` is 1, `cas_in` is also ORed in. The sum appears on `cas_out` in the same cycle.
- R3: The combinational result is the sum XOR an operand. `cfg_xor_mode` selects the operand: 0 gives constant 0, 1 gives constant 1 (inverted polarity), 2 gives product term `pt[cfg_xor_pt]`, and 3 acts as 0.
- R4: `cfg_data_src` selects the storage data input: 0 is the XOR result, 1 is `pt[cfg_data_pt]`, 2 is `pin_in`, and 3 acts as 0.
- R5: `cfg_store_mode` 0 is D mode: on a rising edge of the fabric clock, the state loads the data input. `cfg_clk_src` chooses the fabric clock: 0 is `gclk_in`, 1 is `pt[cfg_clk_pt]`. Values 5 to 7 of `cfg_store_mode` act as D.
- R6: `cfg_store_mode` 1 is T mode: on a rising fabric edge, the state inverts when the data input is 1 and holds when it is 0.
- R7: `cfg_store_mode` 2 is JK mode. J is the data input and K is `pt[cfg_aux_pt]`. On a rising fabric edge, J=1 K=0 sets, J=0 K=1 clears, J=K=1 toggles and J=K=0 holds.
- R8: `cfg_store_mode` 3 is SR mode. S is the data input and R is `pt[cfg_aux_pt]`. On a rising fabric edge, S alone sets, R alone clears, and both or neither hold.
- R9: `cfg_store_mode` 4 is latch mode. While the fabric clock is high, the state follows the data input one system cycle later. While the fabric clock is low, the state holds.
- R10: With the global clock selected and `cfg_ce_en` = 1, product term `pt[cfg_ce_pt]` is a clock enable. Fabric edges and latch transparency are ignored while it is 0.
- R11: `cfg_rst_mode` selects the reset source: 0 none, 1 `gclr_in`, 2 `pt[cfg_rst_pt]`, 3 either. When `cfg_pre_en` is 1, preset is `pt[cfg_pre_pt]`. An active reset clears the state and an active preset sets it. Reset wins when both are active.
- R12: `pin_out` is the state when `cfg_out_reg` = 1 and the combinational XOR result when it is 0. `fb_out` makes the same choice on its own, using `cfg_fb_reg`.
- R13: `cfg_oe_mode` selects `pin_oe`: 0 always low, 1 always high, 2 `goe_in[cfg_oe_sel]`, 3 `pt[cfg_oe_sel]`. An index out of range gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state and sampling |
| rst_n | input | 1 | Synchronous active-low reset; captures configuration |
| pt | input | NUM_PT (5) | Product-term values from the AND array |
| cas_in | input | 1 | Sum from the neighbouring cell |
| gclk_in | input | 1 | Global fabric clock level |
| gclr_in | input | 1 | Global clear |
| goe_in | input | NUM_GOE (6) | Global output enables |
| pin_in | input | 1 | Pin input value |
| cfg_sum_mask | input | NUM_PT | Product terms that feed the sum |
| cfg_cas_en | input | 1 | Include cas_in in the sum |
| cfg_xor_mode | input | 2 | XOR operand select |
| cfg_xor_pt | input | IDX_W (3) | Product term for the XOR operand |
| cfg_data_src | input | 2 | Storage data source |
| cfg_data_pt | input | IDX_W | Product term for data |
| cfg_store_mode | input | 3 | Storage mode |
| cfg_aux_pt | input | IDX_W | Product term for K or R |
| cfg_clk_src | input | 1 | 0 global clock, 1 product term |
| cfg_clk_pt | input | IDX_W | Product term used as clock |
| cfg_ce_en | input | 1 | Enable the clock-enable term |
| cfg_ce_pt | input | IDX_W | Product term used as clock enable |
| cfg_rst_mode | input | 2 | Reset source select |
| cfg_rst_pt | input | IDX_W | Product term used as reset |
| cfg_pre_en | input | 1 | Enable the preset term |
| cfg_pre_pt | input | IDX_W | Product term used as preset |
| cfg_out_reg | input | 1 | Pin output registered (1) or combinational (0) |
| cfg_fb_reg | input | 1 | Feedback registered (1) or combinational (0) |
| cfg_oe_mode | input | 2 | Output-enable select |
| cfg_oe_sel | input | OES_W (3) | Global enable index or product-term index |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| fb_out | output | 1 | Buried feedback |
| cas_out | output | 1 | Sum to the next cell |

## Verification
A wrong stored state cannot be seen on `pin_out` while that output is combinational. The bench therefore reads it through whichever of `pin_out` or `fb_out` is registered, one system cycle after the edge that should have changed it. A wrong edge detector or enable shows up as a state that moves one pulse early, one pulse late or not at all. A wrong captured configuration shows up on the first combinational check after reset. It also shows up when a setting changed after reset unexpectedly alters the ports.

// File: rtl/plm_macrocell_pkg.sv
// Shared encodings for the macrocell configuration fields.
// Assumes the encodings listed in the requirements; reserved codes are
// handled by each consumer as documented there.
package plm_macrocell_pkg;

    typedef enum logic [1:0] {XB_ZERO = 2'd0, XB_ONE = 2'd1, XB_PT = 2'd2, XB_RSVD = 2'd3} xor_b_e;
    typedef enum logic [1:0] {DS_XOR = 2'd0, DS_PT = 2'd1, DS_PIN = 2'd2, DS_RSVD = 2'd3} data_src_e;
    typedef enum logic [2:0] {SM_D = 3'd0, SM_T = 3'd1, SM_JK = 3'd2, SM_SR = 3'd3, SM_LATCH = 3'd4} store_e;
    typedef enum logic [1:0] {RS_NONE = 2'd0, RS_GCLR = 2'd1, RS_PT = 2'd2, RS_BOTH = 2'd3} rst_src_e;
    typedef enum logic [1:0] {OE_OFF = 2'd0, OE_ON = 2'd1, OE_GLOBAL = 2'd2, OE_PT = 2'd3} oe_src_e;

endpackage

// File: rtl/plm_mc_steer.sv
// Product-term steering, sum and XOR stage.
// Forms the masked sum (with optional cascade), the XOR result and picks
// the product terms used as storage data, K/R, clock, enable, reset, preset.
// Assumes indexes at or beyond NUM_PT select a constant 0.
module plm_mc_steer
    import plm_macrocell_pkg::*;
#(
    parameter int NUM_PT = 5,
    localparam int IDX_W = $clog2(NUM_PT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PT-1:0] pt,
    input  logic              cas_in,
    input  logic              pin_in,
    input  logic [NUM_PT-1:0] sum_mask,
    input  logic              cas_en,
    input  xor_b_e            xor_mode,
    input  logic [IDX_W-1:0]  xor_pt,
    input  data_src_e         data_src,
    input  logic [IDX_W-1:0]  data_pt,
    input  logic [IDX_W-1:0]  aux_pt,
    input  logic [IDX_W-1:0]  clk_pt,
    input  logic [IDX_W-1:0]  ce_pt,
    input  logic [IDX_W-1:0]  rst_pt,
    input  logic [IDX_W-1:0]  pre_pt,
    output logic              sum_out,
    output logic              comb_out,
    output logic              d_val,
    output logic              aux_val,
    output logic              clk_pt_val,
    output logic              ce_val,
    output logic              rst_pt_val,
    output logic              pre_pt_val
);

    // Select one product term by index; out-of-range gives 0.
    function automatic logic pick(input logic [NUM_PT-1:0] v, input logic [IDX_W-1:0] i);
        logic r;
        r = 1'b0;
        for (int k = 0; k < NUM_PT; k++) begin
            if (i == IDX_W'(k)) r = v[k];
        end
        return r;
    endfunction

    logic xor_b;

    // Sum of masked product terms plus optional cascade input.
    always_comb sum_out = (|(pt & sum_mask)) | (cas_en & cas_in);

    // Second XOR operand: constant or product term.
    always_comb begin
        unique case (xor_mode)
            XB_ONE:  xor_b = 1'b1;
            XB_PT:   xor_b = pick(pt, xor_pt);
            default: xor_b = 1'b0;
        endcase
    end

    // Polarity / XOR stage.
    always_comb comb_out = sum_out ^ xor_b;

    // Storage data source.
    always_comb begin
        unique case (data_src)
            DS_PT:   d_val = pick(pt, data_pt);
            DS_PIN:  d_val = pin_in;
            DS_XOR:  d_val = comb_out;
            default: d_val = 1'b0;
        endcase
    end

    // Control product terms for the storage element.
    always_comb begin
        aux_val    = pick(pt, aux_pt);
        clk_pt_val = pick(pt, clk_pt);
        ce_val     = pick(pt, ce_pt);
        rst_pt_val = pick(pt, rst_pt);
        pre_pt_val = pick(pt, pre_pt);
    end

    // R2: an enabled cascade input always forces the sum high.
    a_r2_cascade_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_en && cas_in) |-> sum_out);
    // R2: nothing enabled means the sum is low.
    a_r2_sum_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_en && ((pt & sum_mask) == '0)) |-> !sum_out);
    // R3: constant-one operand inverts the sum.
    a_r3_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (xor_mode == XB_ONE) |-> (comb_out != sum_out));

endmodule

// File: rtl/plm_mc_storage.sv
// Multi-mode storage element with selectable clock, enable, reset, preset.
// The fabric clock is a level sampled on clk; a rising fabric edge is a
// high level following a low level one system cycle earlier.
// Assumes reset beats preset, and both beat any clock activity.
module plm_mc_storage
    import plm_macrocell_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  store_e   mode,
    input  logic     clk_src,
    input  logic     ce_en,
    input  rst_src_e rst_mode,
    input  logic     pre_en,
    input  logic     gclk,
    input  logic     gclr,
    input  logic     clk_pt_val,
    input  logic     ce_val,
    input  logic     rst_pt_val,
    input  logic     pre_pt_val,
    input  logic     d_val,
    input  logic     aux_val,
    output logic     q
);

    logic clk_lvl, clk_prev, en, fire, rst_act, pre_act, nxt;

    // Fabric clock level and enable.
    always_comb begin
        clk_lvl = clk_src ? clk_pt_val : gclk;
        en      = (!clk_src && ce_en) ? ce_val : 1'b1;
    end

    // Reset and preset sources.
    always_comb begin
        unique case (rst_mode)
            RS_GCLR: rst_act = gclr;
            RS_PT:   rst_act = rst_pt_val;
            RS_BOTH: rst_act = gclr | rst_pt_val;
            default: rst_act = 1'b0;
        endcase
        pre_act = pre_en & pre_pt_val;
    end

    // Update strobe: level for latch mode, rising edge otherwise.
    always_comb fire = (mode == SM_LATCH) ? (clk_lvl & en) : (clk_lvl & ~clk_prev & en);

    // Next state per mode; T and JK toggle through q XOR 1.
    always_comb begin
        unique case (mode)
            SM_T:  nxt = q ^ d_val;
            SM_JK: nxt = (d_val & aux_val) ? ~q : (d_val ? 1'b1 : (aux_val ? 1'b0 : q));
            SM_SR: nxt = (d_val ^ aux_val) ? d_val : q;
            default: nxt = d_val;
        endcase
    end

    // State register and clock-level history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= 1'b0;
            clk_prev <= 1'b1;
        end else begin
            clk_prev <= clk_lvl;
            if (rst_act)      q <= 1'b0;
            else if (pre_act) q <= 1'b1;
            else if (fire)    q <= nxt;
        end
    end

    // R11: reset clears the state, even with preset active.
    a_r11_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |=> !q);
    // R11: preset alone sets the state.
    a_r11_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_act && pre_act) |=> q);
    // R10: a low clock enable freezes the state.
    a_r10_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_src && ce_en && !ce_val && !rst_act && !pre_act) |=> $stable(q));
    // R9: a latch with its clock low holds.
    a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_LATCH && !clk_lvl && !rst_act && !pre_act) |=> $stable(q));
    // R7: J=K=1 on an enabled edge toggles.
    a_r7_jk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_JK && clk_lvl && !clk_prev && en && d_val && aux_val && !rst_act && !pre_act)
        |=> (q != $past(q)));
    // R8: S=R=1 holds.
    a_r8_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_SR && d_val && aux_val && !rst_act && !pre_act) |=> $stable(q));

endmodule

// File: rtl/plm_mc_outsel.sv
// Output, feedback and output-enable selection.
// Assumes the enable index addresses goe_in in global mode and pt in
// product-term mode; out-of-range indexes give 0.
module plm_mc_outsel
    import plm_macrocell_pkg::*;
#(
    parameter int NUM_PT  = 5,
    parameter int NUM_GOE = 6,
    parameter int OES_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q,
    input  logic               comb,
    input  logic               out_reg,
    input  logic               fb_reg,
    input  oe_src_e            oe_mode,
    input  logic [OES_W-1:0]   oe_sel,
    input  logic [NUM_GOE-1:0] goe,
    input  logic [NUM_PT-1:0]  pt,
    output logic               pin_out,
    output logic               fb_out,
    output logic               pin_oe
);

    logic goe_pick, pt_pick;

    // Index into the global enables and product terms.
    always_comb begin
        goe_pick = 1'b0;
        pt_pick  = 1'b0;
        for (int k = 0; k < NUM_GOE; k++) begin
            if (oe_sel == OES_W'(k)) goe_pick = goe[k];
        end
        for (int k = 0; k < NUM_PT; k++) begin
            if (oe_sel == OES_W'(k)) pt_pick = pt[k];
        end
    end

    // Independent output and feedback choices.
    always_comb begin
        pin_out = out_reg ? q : comb;
        fb_out  = fb_reg ? q : comb;
    end

    // Output-enable source.
    always_comb begin
        unique case (oe_mode)
            OE_ON:     pin_oe = 1'b1;
            OE_GLOBAL: pin_oe = goe_pick;
            OE_PT:     pin_oe = pt_pick;
            default:   pin_oe = 1'b0;
        endcase
    end

    // R13: fixed modes drive fixed enables.
    a_r13_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_mode == OE_OFF) |-> !pin_oe);
    a_r13_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_mode == OE_ON) |-> pin_oe);
    // R12: with both paths registered, pin and feedback agree.
    a_r12_paths_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (out_reg && fb_reg) |-> (pin_out == fb_out));

endmodule

// File: rtl/plm_macrocell.sv
// Top of the configurable macrocell.
// Captures the static configuration while rst_n is low and wires steering,
// storage and output selection together. Assumes configuration is only
// meaningful when held across a reset pulse.
module plm_macrocell
    import plm_macrocell_pkg::*;
#(
    parameter int NUM_PT  = 5,
    parameter int NUM_GOE = 6,
    localparam int IDX_W  = $clog2(NUM_PT),
    localparam int GOE_W  = $clog2(NUM_GOE),
    localparam int OES_W  = (IDX_W > GOE_W) ? IDX_W : GOE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PT-1:0]  pt,
    input  logic               cas_in,
    input  logic               gclk_in,
    input  logic               gclr_in,
    input  logic [NUM_GOE-1:0] goe_in,
    input  logic               pin_in,
    input  logic [NUM_PT-1:0]  cfg_sum_mask,
    input  logic               cfg_cas_en,
    input  logic [1:0]         cfg_xor_mode,
    input  logic [IDX_W-1:0]   cfg_xor_pt,
    input  logic [1:0]         cfg_data_src,
    input  logic [IDX_W-1:0]   cfg_data_pt,
    input  logic [2:0]         cfg_store_mode,
    input  logic [IDX_W-1:0]   cfg_aux_pt,
    input  logic               cfg_clk_src,
    input  logic [IDX_W-1:0]   cfg_clk_pt,
    input  logic               cfg_ce_en,
    input  logic [IDX_W-1:0]   cfg_ce_pt,
    input  logic [1:0]         cfg_rst_mode,
    input  logic [IDX_W-1:0]   cfg_rst_pt,
    input  logic               cfg_pre_en,
    input  logic [IDX_W-1:0]   cfg_pre_pt,
    input  logic               cfg_out_reg,
    input  logic               cfg_fb_reg,
    input  logic [1:0]         cfg_oe_mode,
    input  logic [OES_W-1:0]   cfg_oe_sel,
    output logic               pin_out,
    output logic               pin_oe,
    output logic               fb_out,
    output logic               cas_out
);

    logic [NUM_PT-1:0] sum_mask_q;
    logic              cas_en_q, clk_src_q, ce_en_q, pre_en_q, out_reg_q, fb_reg_q;
    xor_b_e            xor_mode_q;
    data_src_e         data_src_q;
    store_e            store_q;
    rst_src_e          rst_mode_q;
    oe_src_e           oe_mode_q;
    logic [IDX_W-1:0]  xor_pt_q, data_pt_q, aux_pt_q, clk_pt_q, ce_pt_q, rst_pt_q, pre_pt_q;
    logic [OES_W-1:0]  oe_sel_q;

    logic comb, d_val, aux_val, clk_pt_val, ce_val, rst_pt_val, pre_pt_val, q;

    // Configuration capture: loads only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_mask_q <= cfg_sum_mask;
            cas_en_q   <= cfg_cas_en;
            xor_mode_q <= xor_b_e'(cfg_xor_mode);
            xor_pt_q   <= cfg_xor_pt;
            data_src_q <= data_src_e'(cfg_data_src);
            data_pt_q  <= cfg_data_pt;
            store_q    <= (cfg_store_mode > 3'd4) ? SM_D : store_e'(cfg_store_mode);
            aux_pt_q   <= cfg_aux_pt;
            clk_src_q  <= cfg_clk_src;
            clk_pt_q   <= cfg_clk_pt;
            ce_en_q    <= cfg_ce_en;
            ce_pt_q    <= cfg_ce_pt;
            rst_mode_q <= rst_src_e'(cfg_rst_mode);
            rst_pt_q   <= cfg_rst_pt;
            pre_en_q   <= cfg_pre_en;
            pre_pt_q   <= cfg_pre_pt;
            out_reg_q  <= cfg_out_reg;
            fb_reg_q   <= cfg_fb_reg;
            oe_mode_q  <= oe_src_e'(cfg_oe_mode);
            oe_sel_q   <= cfg_oe_sel;
        end
    end

    plm_mc_steer #(.NUM_PT(NUM_PT)) u_steer (
        .clk(clk), .rst_n(rst_n), .pt(pt), .cas_in(cas_in), .pin_in(pin_in),
        .sum_mask(sum_mask_q), .cas_en(cas_en_q), .xor_mode(xor_mode_q), .xor_pt(xor_pt_q),
        .data_src(data_src_q), .data_pt(data_pt_q), .aux_pt(aux_pt_q), .clk_pt(clk_pt_q),
        .ce_pt(ce_pt_q), .rst_pt(rst_pt_q), .pre_pt(pre_pt_q),
        .sum_out(cas_out), .comb_out(comb), .d_val(d_val), .aux_val(aux_val),
        .clk_pt_val(clk_pt_val), .ce_val(ce_val), .rst_pt_val(rst_pt_val), .pre_pt_val(pre_pt_val)
    );

    plm_mc_storage u_store (
        .clk(clk), .rst_n(rst_n), .mode(store_q), .clk_src(clk_src_q), .ce_en(ce_en_q),
        .rst_mode(rst_mode_q), .pre_en(pre_en_q), .gclk(gclk_in), .gclr(gclr_in),
        .clk_pt_val(clk_pt_val), .ce_val(ce_val), .rst_pt_val(rst_pt_val),
        .pre_pt_val(pre_pt_val), .d_val(d_val), .aux_val(aux_val), .q(q)
    );

    plm_mc_outsel #(.NUM_PT(NUM_PT), .NUM_GOE(NUM_GOE), .OES_W(OES_W)) u_out (
        .clk(clk), .rst_n(rst_n), .q(q), .comb(comb), .out_reg(out_reg_q), .fb_reg(fb_reg_q),
        .oe_mode(oe_mode_q), .oe_sel(oe_sel_q), .goe(goe_in), .pt(pt),
        .pin_out(pin_out), .fb_out(fb_out), .pin_oe(pin_oe)
    );

endmodule

// File: tb/plm_macrocell_test.sv
// Directed bench: one task per scenario, each checking its own results.
module plm_macrocell_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] pt;
    logic       cas_in, gclk_in, gclr_in, pin_in;
    logic [5:0] goe_in;
    logic [4:0] cfg_sum_mask;
    logic       cfg_cas_en, cfg_clk_src, cfg_ce_en, cfg_pre_en, cfg_out_reg, cfg_fb_reg;
    logic [1:0] cfg_xor_mode, cfg_data_src, cfg_rst_mode, cfg_oe_mode;
    logic [2:0] cfg_xor_pt, cfg_data_pt, cfg_store_mode, cfg_aux_pt, cfg_clk_pt;
    logic [2:0] cfg_ce_pt, cfg_rst_pt, cfg_pre_pt, cfg_oe_sel;
    logic       pin_out, pin_oe, fb_out, cas_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    plm_macrocell uut (
        .clk(clk), .rst_n(rst_n), .pt(pt), .cas_in(cas_in), .gclk_in(gclk_in),
        .gclr_in(gclr_in), .goe_in(goe_in), .pin_in(pin_in),
        .cfg_sum_mask(cfg_sum_mask), .cfg_cas_en(cfg_cas_en), .cfg_xor_mode(cfg_xor_mode),
        .cfg_xor_pt(cfg_xor_pt), .cfg_data_src(cfg_data_src), .cfg_data_pt(cfg_data_pt),
        .cfg_store_mode(cfg_store_mode), .cfg_aux_pt(cfg_aux_pt), .cfg_clk_src(cfg_clk_src),
        .cfg_clk_pt(cfg_clk_pt), .cfg_ce_en(cfg_ce_en), .cfg_ce_pt(cfg_ce_pt),
        .cfg_rst_mode(cfg_rst_mode), .cfg_rst_pt(cfg_rst_pt), .cfg_pre_en(cfg_pre_en),
        .cfg_pre_pt(cfg_pre_pt), .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg),
        .cfg_oe_mode(cfg_oe_mode), .cfg_oe_sel(cfg_oe_sel),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out), .cas_out(cas_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Neutral configuration and idle inputs.
    task automatic defaults();
        pt = '0; cas_in = 0; gclk_in = 0; gclr_in = 0; pin_in = 0; goe_in = '0;
        cfg_sum_mask = '0; cfg_cas_en = 0; cfg_xor_mode = 2'd0; cfg_xor_pt = 3'd0;
        cfg_data_src = 2'd2; cfg_data_pt = 3'd0; cfg_store_mode = 3'd0; cfg_aux_pt = 3'd1;
        cfg_clk_src = 0; cfg_clk_pt = 3'd0; cfg_ce_en = 0; cfg_ce_pt = 3'd0;
        cfg_rst_mode = 2'd0; cfg_rst_pt = 3'd0; cfg_pre_en = 0; cfg_pre_pt = 3'd0;
        cfg_out_reg = 1; cfg_fb_reg = 1; cfg_oe_mode = 2'd1; cfg_oe_sel = 3'd0;
    endtask

    // Hold reset for two cycles so the current cfg inputs are captured.
    task automatic apply_cfg();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    // One global clock pulse: state updates at the first edge.
    task automatic gpulse();
        gclk_in = 1; tick();
        gclk_in = 0; tick();
    endtask

    task automatic t_reset();
        defaults(); pin_in = 1;
        apply_cfg();
        check("R1 state clear after reset", pin_out, 1'b0);
        gpulse();
        check("R5 D load from pin", pin_out, 1'b1);
        cfg_out_reg = 0;  // not captured: output stays registered
        tick();
        check("R1 cfg change ignored", pin_out, 1'b1);
    endtask

    task automatic t_sum();
        defaults(); cfg_out_reg = 0; cfg_sum_mask = 5'b00101;
        apply_cfg();
        check("R2 sum idle", cas_out, 1'b0);
        pt = 5'b00100; tick();
        check("R2 masked term", cas_out, 1'b1);
        check("R2 comb pin", pin_out, 1'b1);
        pt = 5'b00010; tick();
        check("R2 unmasked term ignored", cas_out, 1'b0);
        pt = '0; cas_in = 1; tick();
        check("R2 cascade disabled", cas_out, 1'b0);
        cfg_cas_en = 1; apply_cfg();
        check("R2 cascade enabled", cas_out, 1'b1);
    endtask

    task automatic t_xor();
        defaults(); cfg_out_reg = 0; cfg_sum_mask = 5'b00001; cfg_xor_mode = 2'd1;
        apply_cfg();
        check("R3 invert of 0", pin_out, 1'b1);
        pt = 5'b00001; tick();
        check("R3 invert of 1", pin_out, 1'b0);
        cfg_xor_mode = 2'd2; cfg_xor_pt = 3'd3; apply_cfg();
        pt = 5'b01001; tick();
        check("R3 pt operand 1^1", pin_out, 1'b0);
        pt = 5'b00001; tick();
        check("R3 pt operand 1^0", pin_out, 1'b1);
    endtask

    task automatic t_data();
        defaults(); cfg_data_src = 2'd1; cfg_data_pt = 3'd2;
        apply_cfg();
        pt = 5'b00100; gpulse();
        check("R4 data from pt", pin_out, 1'b1);
        cfg_data_src = 2'd0; cfg_xor_mode = 2'd1; apply_cfg();
        gpulse();
        check("R4 data from xor", pin_out, 1'b1);
        defaults(); cfg_clk_src = 1; cfg_clk_pt = 3'd4; pin_in = 1;
        apply_cfg();
        gpulse();
        check("R5 global clock unused", pin_out, 1'b0);
        pt = 5'b10000; tick();
        check("R5 pt clock edge", pin_out, 1'b1);
    endtask

    task automatic t_toggle();
        defaults(); cfg_store_mode = 3'd1; pin_in = 1;
        apply_cfg();
        gpulse(); check("R6 T toggle up", pin_out, 1'b1);
        gpulse(); check("R6 T toggle down", pin_out, 1'b0);
        pin_in = 0; gpulse(); check("R6 T hold", pin_out, 1'b0);
    endtask

    task automatic t_jk();
        defaults(); cfg_store_mode = 3'd2; cfg_data_src = 2'd1; cfg_data_pt = 3'd0; cfg_aux_pt = 3'd1;
        apply_cfg();
        pt = 5'b00001; gpulse(); check("R7 JK set", pin_out, 1'b1);
        pt = 5'b00000; gpulse(); check("R7 JK hold", pin_out, 1'b1);
        pt = 5'b00010; gpulse(); check("R7 JK clear", pin_out, 1'b0);
        pt = 5'b00011; gpulse(); check("R7 JK toggle up", pin_out, 1'b1);
        gpulse();                check("R7 JK toggle down", pin_out, 1'b0);
    endtask

    task automatic t_sr();
        defaults(); cfg_store_mode = 3'd3; cfg_data_src = 2'd1; cfg_data_pt = 3'd0; cfg_aux_pt = 3'd1;
        apply_cfg();
        pt = 5'b00001; gpulse(); check("R8 SR set", pin_out, 1'b1);
        pt = 5'b00011; gpulse(); check("R8 SR both hold 1", pin_out, 1'b1);
        pt = 5'b00010; gpulse(); check("R8 SR clear", pin_out, 1'b0);
        pt = 5'b00011; gpulse(); check("R8 SR both hold 0", pin_out, 1'b0);
    endtask

    task automatic t_latch();
        defaults(); cfg_store_mode = 3'd4;
        apply_cfg();
        gclk_in = 1; pin_in = 1; tick(); check("R9 transparent 1", pin_out, 1'b1);
        pin_in = 0; tick();              check("R9 transparent 0", pin_out, 1'b0);
        gclk_in = 0; pin_in = 1; tick(); check("R9 closed", pin_out, 1'b0);
        tick();                          check("R9 closed again", pin_out, 1'b0);
        gclk_in = 1; tick();             check("R9 reopen", pin_out, 1'b1);
    endtask

    task automatic t_enable();
        defaults(); cfg_ce_en = 1; cfg_ce_pt = 3'd2; pin_in = 1;
        apply_cfg();
        gpulse(); check("R10 edge ignored", pin_out, 1'b0);
        pt = 5'b00100; tick();
        check("R10 enable alone no edge", pin_out, 1'b0);
        gpulse(); check("R10 edge taken", pin_out, 1'b1);
    endtask

    task automatic t_resets();
        defaults(); cfg_rst_mode = 2'd2; cfg_rst_pt = 3'd3; pin_in = 1;
        apply_cfg();
        gpulse();
        gclr_in = 1; tick(); check("R11 gclr ignored in pt mode", pin_out, 1'b1);
        gclr_in = 0;
        cfg_rst_mode = 2'd3; cfg_pre_en = 1; cfg_pre_pt = 3'd4; apply_cfg();
        gpulse();
        gclr_in = 1; tick(); check("R11 gclr clears", pin_out, 1'b0);
        gclr_in = 0; pt = 5'b10000; tick(); check("R11 preset sets", pin_out, 1'b1);
        pt = 5'b01000; tick(); check("R11 pt reset clears", pin_out, 1'b0);
        pt = 5'b11000; tick(); check("R11 reset beats preset", pin_out, 1'b0);
        pt = '0; tick();
    endtask

    task automatic t_paths();
        defaults(); cfg_fb_reg = 0; pin_in = 1;
        apply_cfg();
        gpulse();
        check("R12 pin registered", pin_out, 1'b1);
        check("R12 fb combinational", fb_out, 1'b0);
        cfg_out_reg = 0; cfg_fb_reg = 1; cfg_xor_mode = 2'd1; apply_cfg();
        check("R12 pin combinational", pin_out, 1'b1);
        check("R12 fb registered", fb_out, 1'b0);
    endtask

    task automatic t_oe();
        defaults(); cfg_oe_mode = 2'd0; goe_in = '1; pt = '1;
        apply_cfg();
        check("R13 oe off", pin_oe, 1'b0);
        cfg_oe_mode = 2'd1; goe_in = '0; pt = '0; apply_cfg();
        check("R13 oe on", pin_oe, 1'b1);
        cfg_oe_mode = 2'd2; cfg_oe_sel = 3'd4; apply_cfg();
        goe_in = 6'b010000; tick(); check("R13 global 4 high", pin_oe, 1'b1);
        goe_in = 6'b101111; tick(); check("R13 global 4 low", pin_oe, 1'b0);
        cfg_oe_mode = 2'd3; cfg_oe_sel = 3'd1; goe_in = '0; apply_cfg();
        pt = 5'b00010; tick(); check("R13 pt enable high", pin_oe, 1'b1);
        pt = 5'b11101; tick(); check("R13 pt enable low", pin_oe, 1'b0);
    endtask

    initial begin
        defaults();
        rst_n = 0;
        t_reset();
        t_sum();
        t_xor();
        t_data();
        t_toggle();
        t_jk();
        t_sr();
        t_latch();
        t_enable();
        t_resets();
        t_paths();
        t_oe();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule